// File: doc/BRIEF.md
# Infrared SIR Receive Pulse Stretcher

This block sits between an infrared photodetector front end and a UART receiver. Each zero bit arrives on the receive line as one short pulse. A one bit arrives as a bit time with no pulse. The block recovers the NRZ level: every detected pulse becomes a low output that lasts exactly one bit time, which is sixteen cycles of the 16x baud-rate clock. While no pulses arrive, the output rests high.

The raw line is asynchronous to the clock. It passes through a two-flop synchroniser, so the delay from a pulse edge to the output falling edge is always the same. A polarity input chooses the active edge. With a detector that inverts and idles high, the active edge is the falling edge. With a non-inverting detector that idles low, it is the rising edge. A new active edge that arrives during a stretch restarts the count. A pulse that comes one clock late therefore shows up only as a single-cycle high blip between two zero bits. A UART that samples in the middle of the bit ignores that blip.

Top module: `irda_sir_decoder`

## Requirements
- R1: While reset is asserted, and after it is released with no active edge, `rx_nrz` is high and the stretch counter holds zero.
- R2: An active transition of `rx_raw` is first registered by the third rising clock edge after it occurs, and `rx_nrz` goes low at that edge. The synchroniser takes two edges and the edge register takes one.
- R3: Once low, `rx_nrz` stays low for exactly 16 clock cycles (BIT_CYCLES) and then returns high, provided no further active edge is detected.
- R4: When no active edge occurs, `rx_nrz` stays high. A receive level that is held steady, even at the active level, yields at most one stretch.
- R5: With `pulse_pol` = 0, only falling edges of `rx_raw` are active. With `pulse_pol` = 1, only rising edges are active.
- R6: An active edge detected while `rx_nrz` is low restarts the count. The output then returns high 16 cycles after that latest edge was registered.
- R7: Active edges spaced 17 clocks apart produce exactly one high cycle between the two lows. Edges spaced 16 clocks apart produce one continuous low.
- R8: Changing `pulse_pol` while `rx_raw` is static causes no stretch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_16x | input | 1 | Clock at 16 times the baud rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_raw | input | 1 | Raw pulse line from the detector, asynchronous |
| pulse_pol | input | 1 | Active-edge select: 0 = falling, 1 = rising |
| rx_nrz | output | 1 | Recovered NRZ serial data, idles high |

## Verification
The bench targets the following cases; the expected failure of each is noted:
- Pulse trains spaced 16 and 17 clocks apart. A stretcher that ignores edges while busy would open a high gap where a zero should continue. A counter off by one would merge or split the blip.
- An early retrigger in the middle of a stretch. A design that fails to clear its count would release the output too soon.
- Flipping the polarity while the line is static. An edge detector that compares against a history taken under the old polarity would produce a spurious zero bit.
- Long runs held at the active level. These expose a level-sensitive detector, which would hold the output low indefinitely.

// File: rtl/irda_sir_decoder.sv
module irda_sir_decoder #(
  parameter int BIT_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_16x,
  input  logic rst_n,
  input  logic rx_raw,
  input  logic pulse_pol,
  output logic rx_nrz
);

  localparam int CNT_W = $clog2(BIT_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   busy_q;
  logic [CNT_W-1:0]       cnt_q;

  always_ff @(posedge clk_16x or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rx_raw};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  wire line_now  = sync_q[SYNC_STAGES-1];
  wire act_now   = line_now ^ ~pulse_pol;
  wire act_prev  = prev_q ^ ~pulse_pol;
  wire edge_det  = act_now & ~act_prev;

  always_ff @(posedge clk_16x or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (edge_det) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign rx_nrz = ~busy_q;

  AST_IDLE_CNT_CLEAR: assert property (@(posedge clk_16x) disable iff (!rst_n)
    rx_nrz |-> cnt_q == '0); // R1
  AST_EDGE_TO_LOW: assert property (@(posedge clk_16x) disable iff (!rst_n)
    edge_det |=> !rx_nrz); // R2
  AST_LOW_HOLDS: assert property (@(posedge clk_16x) disable iff (!rst_n)
    (!rx_nrz && cnt_q != LAST) |=> !rx_nrz); // R3
  AST_RISE_AT_END: assert property (@(posedge clk_16x) disable iff (!rst_n)
    $rose(rx_nrz) |-> $past(cnt_q) == LAST); // R3
  AST_QUIET_STAYS_HIGH: assert property (@(posedge clk_16x) disable iff (!rst_n)
    (rx_nrz && !edge_det) |=> rx_nrz); // R4
  AST_EDGE_POLARITY: assert property (@(posedge clk_16x) disable iff (!rst_n)
    edge_det |-> (line_now == pulse_pol) && (prev_q != pulse_pol)); // R5
  AST_RESTART_CLEARS: assert property (@(posedge clk_16x) disable iff (!rst_n)
    (busy_q && edge_det) |=> (cnt_q == '0 && !rx_nrz)); // R6

endmodule

// File: tb/irda_sir_decoder_tb.sv
`timescale 1ns/1ps
module irda_sir_decoder_tb;
  localparam int LAT = 3;
  localparam int SPAN = 16;
  localparam int HMAX = 16384;

  logic clk_16x = 1'b0;
  logic rst_n = 1'b0;
  logic rx_raw = 1'b1;
  logic pulse_pol = 1'b0;
  logic rx_nrz;

  irda_sir_decoder u_dut (
    .clk_16x(clk_16x), .rst_n(rst_n), .rx_raw(rx_raw),
    .pulse_pol(pulse_pol), .rx_nrz(rx_nrz)
  );

  always #2.5 clk_16x = ~clk_16x;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  string tag = "R1";
  logic raw_h [0:HMAX-1];
  logic pol_h [0:HMAX-1];

  function automatic logic active_edge(int k);
    logic p;
    p = pol_h[k+2];
    return (p ? raw_h[k] : ~raw_h[k]) & ~(p ? raw_h[k-1] : ~raw_h[k-1]);
  endfunction

  function automatic logic expect_out(int n);
    for (int d = LAT; d < LAT + SPAN; d++) begin
      if (n - d >= 1 && active_edge(n - d)) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check(input logic act, input logic exp, input string t);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: rx_nrz=%0b expected %0b", t, cyc, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic p);
    @(negedge clk_16x);
    cyc++;
    check(rx_nrz, expect_out(cyc), tag);
    raw_h[cyc] = r;
    pol_h[cyc] = p;
    rx_raw = r;
    pulse_pol = p;
  endtask

  task automatic idle(input int n, input logic p);
    for (int i = 0; i < n; i++) step(~p, p);
  endtask

  task automatic pulse(input int width, input int gap, input logic p);
    for (int i = 0; i < width; i++) step(p, p);
    for (int i = 0; i < gap; i++) step(~p, p);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  initial begin
    for (int i = 0; i < HMAX; i++) begin raw_h[i] = 1'b1; pol_h[i] = 1'b0; end
    repeat (4) @(negedge clk_16x);
    tag = "R1";
    check(rx_nrz, 1'b1, "R1 in reset");
    rst_n = 1'b1;
    cyc = 0;
    idle(10, 1'b0);

    tag = "R2 R3";
    pulse(3, 30, 1'b0);
    pulse(1, 30, 1'b0);

    tag = "R4";
    idle(40, 1'b0);
    for (int i = 0; i < 60; i++) step(1'b0, 1'b0);
    idle(30, 1'b0);

    tag = "R5";
    idle(5, 1'b1);
    pulse(2, 25, 1'b1);
    pulse(4, 25, 1'b1);
    pulse(1, 25, 1'b1);

    tag = "R6";
    idle(5, 1'b0);
    pulse(2, 6, 1'b0);
    pulse(2, 30, 1'b0);

    tag = "R7";
    pulse(3, 13, 1'b0);
    pulse(3, 13, 1'b0);
    pulse(3, 30, 1'b0);
    pulse(3, 14, 1'b0);
    pulse(3, 14, 1'b0);
    pulse(3, 30, 1'b0);

    tag = "R8";
    for (int i = 0; i < 6; i++) step(1'b1, i[0]);
    step(1'b1, 1'b0);
    idle(25, 1'b0);

    tag = "R7 random";
    begin
      int seed_dummy;
      logic p;
      seed_dummy = $urandom(32'h5eed_1234);
      p = 1'b0;
      for (int seg = 0; seg < 40; seg++) begin
        if ($urandom_range(0, 3) == 0) p = ~p;
        idle(3, p);
        for (int b = 0; b < 6; b++) begin
          int w;
          int gap;
          w = $urandom_range(1, 4);
          gap = $urandom_range(12, 20) - w;
          pulse(w, gap, p);
        end
        idle(int'($urandom_range(5, 25)), p);
      end
    end
    idle(25, 1'b0);
    finish_run();
  end
endmodule